// File: doc/BRIEF.md
# Lockstep Fault-Injection Trial Controller

This block runs a fault-injection campaign over a range of location indices. Two copies of the same design sit outside it: the device under test and a golden reference. Both copies receive one shared pseudo-random stimulus word on every cycle. The block compares their 72-bit result buses and keeps a sticky mismatch flag. An external agent upsets and restores the fault location; it acts on the block's inject and repair strobes.

For each location the sequencer runs one trial:
- It pulses inject.
- It lets both copies run for a programmable number of cycles.
- It samples the mismatch flag. If the flag is set, it reports the location with a one-cycle strobe.
- It pulses repair.
- It resets both copies. This reset also clears the flag and reseeds the stimulus generator, so every trial replays the same stimulus.

The campaign starts with a one-cycle start request. It ends with a done pulse after the last location.

Top module: `lockstep_fault_campaign`

## Requirements
- R1: The stimulus word is a 32-bit shift register. On each step it moves left by one bit, and its new bit 0 is the XOR of its bits 31, 21, 1 and 0. It steps on every cycle in which `copy_rst` is low.
- R2: In every cycle with `copy_rst` high, the shift register loads the seed (default 32'hACE12B5D). As a result, the stimulus word equals the seed in the inject cycle of every trial.
- R3: The mismatch flag rises one cycle after any cycle in which `dut_bus` and `gold_bus` differ in any bit while `copy_rst` is low.
- R4: Once set, the mismatch flag stays set until a cycle with `copy_rst` high. It is low in the cycle after that.
- R5: A trial runs in this order: `inject_pulse` for one cycle, an observation window, one check cycle, `repair_pulse` for one cycle, then one cycle of `copy_rst`. `repair_pulse` rises exactly N+2 cycles after `inject_pulse` for a window of N.
- R6: The window length is sampled from `window_len` in the inject cycle of each trial. A value of 0 behaves as 1.
- R7: In the check cycle, if the mismatch flag is set, `fail_valid` is high for exactly one cycle, and `cur_loc` holds the location under trial. That cycle falls N+1 cycles after inject.
- R8: Trials cover `loc_first` up to `loc_last`, with the index rising by one per trial. If `loc_first` is greater than `loc_last`, a single trial runs at `loc_first`.
- R9: After the last trial's reset cycle, `done` pulses for one cycle while `copy_rst` stays high. On the following cycle `busy` is low.
- R10: After reset and while idle: `busy` is low, `copy_rst` is high, no strobe is active, the mismatch flag is clear, and the stimulus word equals the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a campaign when idle |
| loc_first | input | 16 | First location index |
| loc_last | input | 16 | Last location index |
| window_len | input | 16 | Observation window in cycles |
| test_vec | output | 32 | Stimulus word shared by both copies |
| copy_rst | output | 1 | Reset for both design copies |
| inject_pulse | output | 1 | Request to upset the current location |
| repair_pulse | output | 1 | Request to restore the current location |
| dut_bus | input | 72 | Result bus of the device under test |
| gold_bus | input | 72 | Result bus of the golden copy |
| mismatch | output | 1 | Sticky difference flag |
| fail_valid | output | 1 | One-cycle failure report |
| cur_loc | output | 16 | Location under trial |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | One-cycle end-of-campaign pulse |

## Verification
The bench models both copies, and the fault it injects follows the location under trial. It targets the following corner cases:
- A difference lasting one cycle must still be reported. A flag that is not sticky would lose that failure before the check cycle.
- A zero window must act as a one-cycle window. A counter that underflows would hang or stretch the trial.
- A reversed location range must run exactly one trial. A design that compares only for equality with the last index would wrap through the whole index space.
- The stimulus word must equal the seed at every inject. If the reseed were missed, every trial would see a different stimulus.

// File: rtl/fic_pkg.sv
package fic_pkg;

    localparam int VEC_W = 32;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_INJECT,
        SQ_OBSERVE,
        SQ_CHECK,
        SQ_REPAIR,
        SQ_RESET,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic inject;
        logic repair;
        logic copy_rst;
        logic check;
    } seq_ctl_t;

    // Left shift; feedback taps at bits 31, 21, 1, 0.
    function automatic logic [VEC_W-1:0] vec_step(input logic [VEC_W-1:0] s);
        return {s[VEC_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/fic_vec_gen.sv
module fic_vec_gen
    import fic_pkg::*;
#(
    parameter logic [VEC_W-1:0] SEED = 32'hACE1_2B5D
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reseed,
    output logic [VEC_W-1:0] vec
);

    logic [VEC_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst || reseed) begin
            state_q <= SEED;
        end else begin
            state_q <= vec_step(state_q);
        end
    end

    assign vec = state_q;

    AST_RESEED_LOADS: assert property (@(posedge clk) disable iff (rst)
        reseed |=> (vec == SEED)); // R2
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        vec != '0); // R1

endmodule

// File: rtl/fic_out_cmp.sv
module fic_out_cmp #(
    parameter int BUS_W = 72
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [BUS_W-1:0] bus_a,
    input  logic [BUS_W-1:0] bus_b,
    output logic             flag
);

    logic differ;
    logic flag_q;

    assign differ = |(bus_a ^ bus_b);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag_q <= 1'b0;
        end else if (differ) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

    AST_DIFF_RAISES: assert property (@(posedge clk) disable iff (rst)
        (differ && !clr) |=> flag); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R4
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag); // R4

endmodule

// File: rtl/fic_trial_seq.sv
module fic_trial_seq
    import fic_pkg::*;
#(
    parameter int LOC_W = 16,
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LOC_W-1:0] loc_first,
    input  logic [LOC_W-1:0] loc_last,
    input  logic [WIN_W-1:0] window_len,
    input  logic             flag,
    output seq_ctl_t         ctl,
    output logic             fail_valid,
    output logic [LOC_W-1:0] loc,
    output logic             busy,
    output logic             done
);

    localparam logic [WIN_W-1:0] WIN_ONE = WIN_W'(1);
    localparam logic [LOC_W-1:0] LOC_ONE = LOC_W'(1);

    seq_state_e       st_q;
    logic [LOC_W-1:0] loc_q;
    logic [WIN_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            loc_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        loc_q <= loc_first;
                        st_q  <= SQ_INJECT;
                    end
                end
                SQ_INJECT: begin
                    cnt_q <= (window_len == '0) ? WIN_ONE : window_len;
                    st_q  <= SQ_OBSERVE;
                end
                SQ_OBSERVE: begin
                    if (cnt_q <= WIN_ONE) begin
                        st_q <= SQ_CHECK;
                    end else begin
                        cnt_q <= cnt_q - WIN_ONE;
                    end
                end
                SQ_CHECK:  st_q <= SQ_REPAIR;
                SQ_REPAIR: st_q <= SQ_RESET;
                SQ_RESET: begin
                    if (loc_q >= loc_last) begin
                        st_q <= SQ_DONE;
                    end else begin
                        loc_q <= loc_q + LOC_ONE;
                        st_q  <= SQ_INJECT;
                    end
                end
                SQ_DONE:   st_q <= SQ_IDLE;
                default:   st_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl.inject   = (st_q == SQ_INJECT);
        ctl.repair   = (st_q == SQ_REPAIR);
        ctl.check    = (st_q == SQ_CHECK);
        ctl.copy_rst = (st_q == SQ_IDLE) || (st_q == SQ_RESET) || (st_q == SQ_DONE);
    end

    assign fail_valid = ctl.check && flag;
    assign loc        = loc_q;
    assign busy       = (st_q != SQ_IDLE);
    assign done       = (st_q == SQ_DONE);

    AST_INJECT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl.inject |=> !ctl.inject); // R5
    AST_REPAIR_THEN_RESET: assert property (@(posedge clk) disable iff (rst)
        ctl.repair |=> ctl.copy_rst); // R5
    AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fail_valid |=> !fail_valid); // R7
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R9
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.inject, ctl.repair, ctl.check})); // R5

endmodule

// File: rtl/lockstep_fault_campaign.sv
module lockstep_fault_campaign
    import fic_pkg::*;
#(
    parameter logic [VEC_W-1:0] SEED  = 32'hACE1_2B5D,
    parameter int               BUS_W = 72,
    parameter int               LOC_W = 16,
    parameter int               WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LOC_W-1:0] loc_first,
    input  logic [LOC_W-1:0] loc_last,
    input  logic [WIN_W-1:0] window_len,
    output logic [VEC_W-1:0] test_vec,
    output logic             copy_rst,
    output logic             inject_pulse,
    output logic             repair_pulse,
    input  logic [BUS_W-1:0] dut_bus,
    input  logic [BUS_W-1:0] gold_bus,
    output logic             mismatch,
    output logic             fail_valid,
    output logic [LOC_W-1:0] cur_loc,
    output logic             busy,
    output logic             done
);

    seq_ctl_t ctl;
    logic     flag;

    fic_vec_gen #(.SEED(SEED)) u_vec (
        .clk    (clk),
        .rst    (rst),
        .reseed (ctl.copy_rst),
        .vec    (test_vec)
    );

    fic_out_cmp #(.BUS_W(BUS_W)) u_cmp (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctl.copy_rst),
        .bus_a (dut_bus),
        .bus_b (gold_bus),
        .flag  (flag)
    );

    fic_trial_seq #(.LOC_W(LOC_W), .WIN_W(WIN_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .loc_first  (loc_first),
        .loc_last   (loc_last),
        .window_len (window_len),
        .flag       (flag),
        .ctl        (ctl),
        .fail_valid (fail_valid),
        .loc        (cur_loc),
        .busy       (busy),
        .done       (done)
    );

    assign copy_rst     = ctl.copy_rst;
    assign inject_pulse = ctl.inject;
    assign repair_pulse = ctl.repair;
    assign mismatch     = flag;

endmodule

// File: tb/lockstep_fault_campaign_test.sv
module lockstep_fault_campaign_test;

    localparam logic [31:0] SEED  = 32'hACE1_2B5D;
    localparam logic [71:0] FMASK = 72'h1 << 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] loc_first = '0, loc_last = '0, window_len = '0;
    logic [31:0] test_vec;
    logic        copy_rst, inject_pulse, repair_pulse, mismatch, fail_valid, busy, done;
    logic [15:0] cur_loc;
    logic [71:0] dut_bus, gold_bus;
    logic        fault_on = 1'b0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    // Bench copies: identical combinational functions of the shared word.
    assign gold_bus = {test_vec[7:0] ^ 8'h5A, test_vec, ~test_vec};
    assign dut_bus  = gold_bus ^ (fault_on ? FMASK : 72'h0);

    always #4 clk = ~clk;

    lockstep_fault_campaign uut (
        .clk(clk), .rst(rst), .start(start), .loc_first(loc_first),
        .loc_last(loc_last), .window_len(window_len), .test_vec(test_vec),
        .copy_rst(copy_rst), .inject_pulse(inject_pulse), .repair_pulse(repair_pulse),
        .dut_bus(dut_bus), .gold_bus(gold_bus), .mismatch(mismatch),
        .fail_valid(fail_valid), .cur_loc(cur_loc), .busy(busy), .done(done)
    );

    function automatic logic [31:0] model_step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    // Campaign statistics
    int          n_inj, n_rep, n_fail, gap_rep, gap_fail;
    logic [31:0] fail_set, inj_set;
    bit          seed_bad, clr_bad, stick_bad, order_bad, saw_done;

    task automatic run_campaign(input int first, input int last, input int win,
                                input logic [31:0] faulty, input bit glitch);
        int inj_cyc = 0;
        int prev_loc = -1;
        n_inj = 0; n_rep = 0; n_fail = 0; gap_rep = -1; gap_fail = -1;
        fail_set = '0; inj_set = '0;
        seed_bad = 0; clr_bad = 0; stick_bad = 0; order_bad = 0; saw_done = 0;
        loc_first = 16'(first); loc_last = 16'(last); window_len = 16'(win);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int k = 0; k < 5000 && !saw_done; k++) begin
            if (inject_pulse) begin
                n_inj++;
                inj_cyc = cyc;
                inj_set[cur_loc[4:0]] = 1'b1;
                if (test_vec != SEED) seed_bad = 1;
                if (mismatch) clr_bad = 1;
                if (prev_loc >= 0 && int'(cur_loc) != prev_loc + 1) order_bad = 1;
                prev_loc = int'(cur_loc);
                if (faulty[cur_loc[4:0]]) fault_on = 1'b1;
            end else if (glitch && fault_on) begin
                fault_on = 1'b0;
            end
            if (fail_valid) begin
                n_fail++;
                fail_set[cur_loc[4:0]] = 1'b1;
                gap_fail = cyc - inj_cyc;
            end
            if (repair_pulse) begin
                n_rep++;
                gap_rep = cyc - inj_cyc;
                if (faulty[cur_loc[4:0]] && !mismatch) stick_bad = 1;
                fault_on = 1'b0;
            end
            if (done) saw_done = 1;
            tick();
        end
    endtask

    task automatic t_reset();
        chk(!busy, "R10", "busy after reset", 72'(busy), 72'd0);
        chk(copy_rst, "R10", "copy_rst while idle", 72'(copy_rst), 72'd1);
        chk(!inject_pulse && !repair_pulse && !fail_valid && !done, "R10", "strobes idle",
            72'({inject_pulse, repair_pulse, fail_valid, done}), 72'd0);
        chk(!mismatch, "R10", "flag clear", 72'(mismatch), 72'd0);
        chk(test_vec == SEED, "R10", "vector at seed", 72'(test_vec), 72'(SEED));
    endtask

    task automatic t_vectors();
        logic [31:0] m = SEED;
        bit ok = 1;
        logic [31:0] bad_act = '0, bad_exp = '0;
        loc_first = 16'd0; loc_last = 16'd0; window_len = 16'd12;
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(inject_pulse && test_vec == SEED, "R2", "seed in inject cycle", 72'(test_vec), 72'(SEED));
        for (int k = 0; k < 8; k++) begin
            if (test_vec != m && ok) begin ok = 0; bad_act = test_vec; bad_exp = m; end
            m = model_step(m);
            tick();
        end
        chk(ok, "R1", "shift register sequence", 72'(bad_act), 72'(bad_exp));
        for (int k = 0; k < 100 && !done; k++) tick();
        tick();
        chk(!busy, "R9", "idle after single trial", 72'(busy), 72'd0);
    endtask

    task automatic t_sweep();
        run_campaign(2, 6, 8, 32'h28, 0);
        chk(fail_set == 32'h28, "R7", "failing locations", 72'(fail_set), 72'h28);
        chk(n_fail == 2, "R3", "failure count", 72'(n_fail), 72'd2);
        chk(inj_set == 32'h7C && n_inj == 5, "R8", "locations tried", 72'(inj_set), 72'h7C);
        chk(!order_bad, "R8", "index rises by one", 72'(order_bad), 72'd0);
        chk(n_rep == 5, "R5", "repair count", 72'(n_rep), 72'd5);
        chk(gap_rep == 10, "R5", "inject to repair gap", 72'(gap_rep), 72'd10);
        chk(gap_fail == 9, "R7", "inject to fail gap", 72'(gap_fail), 72'd9);
        chk(!seed_bad, "R2", "seed at every inject", 72'(seed_bad), 72'd0);
        chk(!clr_bad, "R4", "flag clear after copy reset", 72'(clr_bad), 72'd0);
        chk(saw_done, "R9", "done pulse", 72'(saw_done), 72'd1);
        chk(!busy && copy_rst, "R9", "idle after campaign", 72'({busy, copy_rst}), 72'b01);
    endtask

    task automatic t_glitch();
        run_campaign(7, 7, 20, 32'h80, 1);
        chk(fail_set == 32'h80 && n_fail == 1, "R3", "one-cycle difference reported",
            72'(fail_set), 72'h80);
        chk(!stick_bad, "R4", "flag held to repair", 72'(stick_bad), 72'd0);
        chk(gap_rep == 22, "R5", "long window gap", 72'(gap_rep), 72'd22);
    endtask

    task automatic t_zero_window();
        run_campaign(1, 1, 0, 32'h2, 0);
        chk(gap_rep == 3, "R6", "zero window acts as one", 72'(gap_rep), 72'd3);
        chk(n_fail == 1 && gap_fail == 2, "R7", "fail after short window", 72'(gap_fail), 72'd2);
    endtask

    task automatic t_reversed();
        run_campaign(9, 4, 3, 32'h0, 0);
        chk(n_inj == 1 && inj_set == 32'h200, "R8", "reversed range single trial",
            72'(inj_set), 72'h200);
        chk(n_fail == 0, "R3", "no failure on clean run", 72'(n_fail), 72'd0);
        chk(saw_done, "R9", "done after reversed range", 72'(saw_done), 72'd1);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_vectors();
        t_sweep();
        t_glitch();
        t_zero_window();
        t_reversed();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule